// File: doc/BRIEF.md
# Strobe-Captured Pixel Write Port for a Split, Double-Buffered Frame Store

This block sits between a host processor's asynchronous, multiplexed 16-bit address/data bus and the frame store that feeds an LED matrix refresh engine. The bus strobes clock the host's address and pixel into holding registers directly. No system clock is involved on the host side. When a write cycle ends, a toggle flag carries the event across to the display clock domain. There the held address and data are decoded and committed to one of two RAM banks. One bank holds the upper sixteen rows of a 32x32 panel and the other holds the lower sixteen rows. Each bank holds two complete frame buffers.

The refresh engine reads both banks at the same time through an asynchronous read port. It gives one buffer select, a row within the half and a column, and gets back the pixel for the upper half and the pixel for the lower half together. A one-cycle write pulse for each bank shows when a committed write lands.

Top module: `pixbus_wrport`

## Requirements
- R1: The write address is taken from `bus_ad` at the rising edge of `adv_n`. Later changes on `bus_ad` do not alter the location written.
- R2: The pixel is taken from `bus_ad` at the falling edge of `we_n`. Changes on `bus_ad` while `we_n` stays low do not alter the stored pixel.
- R3: A write is committed when `we_n` rises. Two `clk` flops synchronise the event, and the RAM is written one `clk` cycle after the synchronised edge is detected. The new pixel is readable no later than six `clk` cycles after `we_n` rises.
- R4: Address decode works as follows. Bit 10 chooses frame buffer 0 or 1. Bit 9 chooses the upper half (0) or the lower half (1). Bits 8:5 give the row within that half and bits 4:0 give the column.
- R5: Only `bus_ad[11:0]` of the write data is stored, laid out as red in 11:8, green in 7:4 and blue in 3:0. Bits 15:12 are ignored.
- R6: A write whose address has any of bits 15:11 set changes no RAM location and produces no write pulse.
- R7: The two frame buffers are independent. `rd_buf` chooses which one is read, and `top_pix` and `bot_pix` return the same row and column of both halves at once.
- R8: Each accepted write gives exactly one single-cycle pulse, on `we_top` for the upper half or on `we_bot` for the lower half, never on both. During reset and directly after it, both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad | input | 16 | Shared address/data bus from the host |
| adv_n | input | 1 | Active-low address-valid strobe; rising edge captures the address |
| we_n | input | 1 | Active-low write strobe; falling edge captures data, rising edge ends the write |
| rd_buf | input | 1 | Frame buffer selected for the display read |
| rd_row | input | 4 | Row within each half for the display read |
| rd_col | input | 5 | Column for the display read |
| top_pix | output | 12 | Pixel read from the upper-half bank |
| bot_pix | output | 12 | Pixel read from the lower-half bank |
| we_top | output | 1 | One-cycle pulse when a write lands in the upper-half bank |
| we_bot | output | 1 | One-cycle pulse when a write lands in the lower-half bank |

## Verification
On every display clock cycle, the assertions check that the two bank pulses are mutually exclusive and one cycle wide. They also check that each pulse follows a detected synchronised edge, that no pulse carries an out-of-range address, and that a committed pixel is present in the addressed location on the next cycle. Some behaviour depends on the asynchronous strobe timing and on what the display later reads back, and only the bench's scenarios can show it. This covers the capture edges for address and data, the placement of buffer, half, row and column bits, the discarded upper data nibble, the independence of the buffers, and the absence of side effects from a dropped address.

// File: rtl/pixbus_wrport.sv
module pixbus_wrport #(
  parameter int BUS_W = 16,
  parameter int PIX_W = 12,
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_ad,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic             rd_buf,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [PIX_W-1:0] top_pix,
  output logic [PIX_W-1:0] bot_pix,
  output logic             we_top,
  output logic             we_bot
);
  localparam int HALF_BIT = ROW_W + COL_W;
  localparam int BUF_BIT  = HALF_BIT + 1;
  localparam int IDX_W    = 1 + ROW_W + COL_W;
  localparam int DEPTH    = 1 << IDX_W;

  // host-side capture, clocked by the bus strobes
  logic [BUS_W-1:0] addr_hold;
  logic [PIX_W-1:0] data_hold;
  logic             wr_tog;

  always_ff @(posedge adv_n)
    addr_hold <= bus_ad;

  always_ff @(negedge we_n)
    data_hold <= bus_ad[PIX_W-1:0];

  always_ff @(posedge we_n or negedge rst_n)
    if (!rst_n) wr_tog <= 1'b0;
    else        wr_tog <= ~wr_tog;

  // display-side synchroniser and commit
  logic s1, s2, s3, pend;
  logic [BUS_W-1:0] cmt_addr;
  logic [PIX_W-1:0] cmt_data;
  logic             sync_edge;

  assign sync_edge = s2 ^ s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; pend <= 1'b0;
    end else begin
      s1 <= wr_tog; s2 <= s1; s3 <= s2;
      pend <= sync_edge;
    end

  always_ff @(posedge clk)
    if (sync_edge) begin
      cmt_addr <= addr_hold;
      cmt_data <= data_hold;
    end

  logic             in_range;
  logic [IDX_W-1:0] cmt_idx;

  assign in_range = (cmt_addr[BUS_W-1:BUF_BIT+1] == '0);
  assign cmt_idx  = {cmt_addr[BUF_BIT], cmt_addr[HALF_BIT-1:0]};
  assign we_top   = pend & in_range & ~cmt_addr[HALF_BIT];
  assign we_bot   = pend & in_range &  cmt_addr[HALF_BIT];

  // frame store: two banks, each holding both buffers
  logic [PIX_W-1:0] mem_top [DEPTH];
  logic [PIX_W-1:0] mem_bot [DEPTH];

  always_ff @(posedge clk) begin
    if (we_top) mem_top[cmt_idx] <= cmt_data;
    if (we_bot) mem_bot[cmt_idx] <= cmt_data;
  end

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx  = {rd_buf, rd_row, rd_col};
  assign top_pix = mem_top[rd_idx];
  assign bot_pix = mem_bot[rd_idx];

  AST_NO_DUAL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_top && we_bot)); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_top || we_bot) |=> !(we_top || we_bot)); // R8
  AST_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_top || we_bot) |-> $past(sync_edge)); // R3
  AST_DROP_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_top || we_bot) |-> (cmt_addr[BUS_W-1:BUF_BIT+1] == '0)); // R6
  AST_TOP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_top |=> mem_top[$past(cmt_idx)] == $past(cmt_data)); // R3
  AST_BOT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_bot |=> mem_bot[$past(cmt_idx)] == $past(cmt_data)); // R3
endmodule

// File: tb/pixbus_wrport_test.sv
module pixbus_wrport_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_ad = 16'h0;
  logic        adv_n = 1'b1;
  logic        we_n = 1'b1;
  logic        rd_buf = 1'b0;
  logic [3:0]  rd_row = 4'h0;
  logic [4:0]  rd_col = 5'h0;
  logic [11:0] top_pix, bot_pix;
  logic        we_top, we_bot;

  int checks = 0, fails = 0;
  int n_top = 0, n_bot = 0;

  pixbus_wrport uut (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .adv_n(adv_n), .we_n(we_n),
    .rd_buf(rd_buf), .rd_row(rd_row), .rd_col(rd_col),
    .top_pix(top_pix), .bot_pix(bot_pix), .we_top(we_top), .we_bot(we_bot)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (we_top) n_top++;
    if (we_bot) n_bot++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit b, input bit h, input int row, input int col);
    return {5'b0, b, h, row[3:0], col[4:0]};
  endfunction

  // address phase, data phase with bus noise while we_n is low, then settle
  task automatic bus_write(input logic [15:0] addr, input logic [15:0] data);
    bus_ad = addr;
    #7 adv_n = 1'b0;
    #15 adv_n = 1'b1;
    #3 bus_ad = ~addr;
    #5 bus_ad = data;
    #5 we_n = 1'b0;
    #5 bus_ad = ~data;
    #20 we_n = 1'b1;
    bus_ad = 16'hDEAD;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_at(input bit b, input int row, input int col);
    rd_buf = b; rd_row = row[3:0]; rd_col = col[4:0];
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R8 reset we_top", we_top, 0);
    check("R8 reset we_bot", we_bot, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 post-reset we_top", we_top, 0);
    check("R8 post-reset we_bot", we_bot, 0);
  endtask

  task automatic t_map;
    int t0 = n_top, b0 = n_bot;
    bus_write(mk(0, 0, 3, 7), 16'h0ABC);
    check("R8 one top pulse", n_top - t0, 1);
    check("R8 no bot pulse", n_bot - b0, 0);
    read_at(0, 3, 7);
    check("R1 R2 R3 R4 top pixel", top_pix, 12'hABC);
    bus_write(mk(0, 1, 15, 31), 16'h0123);
    check("R8 one bot pulse", n_bot - b0, 1);
    read_at(0, 15, 31);
    check("R4 bottom pixel", bot_pix, 12'h123);
    read_at(0, 3, 7);
    check("R4 top untouched by bottom write", top_pix, 12'hABC);
  endtask

  task automatic t_buffers;
    bus_write(mk(1, 0, 3, 7), 16'h0F00);
    bus_write(mk(1, 1, 3, 7), 16'h00F0);
    bus_write(mk(0, 1, 3, 7), 16'h000F);
    read_at(1, 3, 7);
    check("R7 buf1 top", top_pix, 12'hF00);
    check("R7 buf1 bot", bot_pix, 12'h0F0);
    read_at(0, 3, 7);
    check("R7 buf0 top kept", top_pix, 12'hABC);
    check("R7 buf0 bot", bot_pix, 12'h00F);
  endtask

  task automatic t_upper_bits;
    bus_write(mk(0, 0, 0, 0), 16'hF5A6);
    read_at(0, 0, 0);
    check("R5 upper nibble ignored", top_pix, 12'h5A6);
  endtask

  task automatic t_drop;
    for (int k = 11; k < 16; k++) begin
      int t0 = n_top, b0 = n_bot;
      bus_write(mk(0, 0, 3, 7) | (16'h1 << k), 16'h0777);
      read_at(0, 3, 7);
      check("R6 dropped write leaves pixel", top_pix, 12'hABC);
      check("R6 dropped write no pulse", (n_top - t0) + (n_bot - b0), 0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_map();
        t_buffers();
        t_upper_bits();
        t_drop();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule